// File: doc/BRIEF.md
# Differential SAR Switch Controller

This block is the digital sequencer behind a differential charge-redistribution converter with ten capacitors on each side of the comparator. A start request begins a conversion. The controller first spends one cycle sampling, with every capacitor on both arms tied to the input. It then runs one trial per bit, from the most significant bit down. In each trial it reads a single-bit comparator decision and decides whether to keep the trial bit.

Each capacitor gets a pair of bottom-plate selects, one for the P arm and one for the N arm. Outside sampling, the two selects of a pair always choose opposite references. The finished code appears on a parallel result register together with a one-cycle done pulse. The result keeps its old value until every bit has been decided.

Top module: `sar_diff_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the controller to idle, clears `result` to zero, holds `done` low, and sets every arm select to the input code 00.
- R2: While idle, every 2-bit arm select on both arms drives 00, which selects the input.
- R3: A start seen at a clock edge while idle makes the next cycle the sample cycle. In that cycle all arm selects are 00. The sample cycle lasts exactly one cycle and is followed by the first trial.
- R4: The first trial presents the code with only the MSB set, which is half of full scale.
- R5: At the clock edge that ends a trial, a comparator value of 1 keeps the trial bit at 1. A value of 0 clears it. In either case the next lower bit becomes the new trial bit, and all higher decided bits are held. This gives 3/4 or 1/4 scale on the second trial.
- R6: During trials, a capacitor whose code bit is 1 has its P-arm select at 01 (positive reference) and its N-arm select at 10 (negative reference). Select field i is bits [2i+1:2i] of `sel_p` / `sel_n`, and capacitor i carries code bit i.
- R7: During trials, a capacitor whose code bit is 0 has its P-arm select at 10 (negative reference) and its N-arm select at 01 (positive reference).
- R8: The select code 11 is never driven on either arm.
- R9: `result` changes only at the edge that ends the last trial, 11 clock edges after the start was captured. `done` is high for exactly the one cycle that follows that edge, and the new result then equals the decided code.
- R10: A start that arrives during the sample cycle or during a trial has no effect. The conversion runs to its normal end and no second conversion follows.
- R11: A start presented during the cycle in which `done` is high is accepted, since the controller is idle then. A new sample cycle follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, honoured only while idle |
| cmp | input | 1 | Comparator decision for the current trial, 1 keeps the trial bit |
| sel_p | output | 20 | P-arm bottom-plate selects, 2 bits per capacitor |
| sel_n | output | 20 | N-arm bottom-plate selects, 2 bits per capacitor |
| result | output | 10 | Last completed conversion code |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Several rules are checked by assertions on every cycle. These are: the absence of the 11 code, the complementary P/N pairing, input selects outside trials, the single-cycle sample phase, the countdown of the bit pointer, the half-scale first trial, the kept bit after a comparator 1, the held result and the one-cycle done pulse. Other behaviours can only be shown by the bench's scenarios. These are: a full binary search converging on a modelled input for boundary codes (0, full scale, mid-scale and alternating patterns), the exact cycle of the result update, a start ignored in mid-conversion, a start accepted during done, and a reset that interrupts a conversion.

// File: rtl/sar_diff_pkg.sv
package sar_diff_pkg;

   typedef enum logic [1:0] {
      ARM_IN = 2'b00,
      ARM_VP = 2'b01,
      ARM_VN = 2'b10
   } arm_sel_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'b00,
      PH_SAMPLE = 2'b01,
      PH_TRIAL  = 2'b10
   } phase_e;

endpackage

// File: rtl/sar_diff_seq.sv
module sar_diff_seq
   import sar_diff_pkg::*;
#(
   parameter int NBITS = 10,
   parameter int PW    = $clog2(NBITS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          in_sample,
   output logic          in_trial,
   output logic [PW-1:0] ptr,
   output logic          last_trial,
   output logic          done
);

   localparam logic [PW-1:0] TOP_BIT = PW'(NBITS - 1);

   phase_e phase;

   assign in_sample  = (phase == PH_SAMPLE);
   assign in_trial   = (phase == PH_TRIAL);
   assign last_trial = in_trial && (ptr == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         ptr   <= '0;
         done  <= 1'b0;
      end else begin
         done <= last_trial;
         unique case (phase)
            PH_IDLE: begin
               if (start) phase <= PH_SAMPLE;
            end
            PH_SAMPLE: begin
               phase <= PH_TRIAL;
               ptr   <= TOP_BIT;
            end
            PH_TRIAL: begin
               if (ptr == '0) phase <= PH_IDLE;
               else           ptr   <= ptr - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   a_r3_one_sample_cycle: assert property (@(posedge clk) disable iff (rst)
      in_sample |=> (in_trial && ptr == TOP_BIT));

   a_r5_pointer_steps_down: assert property (@(posedge clk) disable iff (rst)
      (in_trial && !last_trial) |=> (in_trial && ptr == $past(ptr) - 1'b1));

   a_r10_no_restart_midway: assert property (@(posedge clk) disable iff (rst)
      (in_trial && start) |=> !in_sample);

   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

// File: rtl/sar_diff_code.sv
module sar_diff_code #(
   parameter int NBITS = 10,
   parameter int PW    = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_sample,
   input  logic             in_trial,
   input  logic             last_trial,
   input  logic [PW-1:0]    ptr,
   input  logic             cmp,
   output logic [NBITS-1:0] code,
   output logic [NBITS-1:0] result
);

   localparam logic [NBITS-1:0] HALF_SCALE = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] code_nxt;

   always_comb begin
      code_nxt = code;
      if (in_sample) begin
         code_nxt = HALF_SCALE;
      end else if (in_trial) begin
         code_nxt[ptr] = cmp;
         if (ptr != '0) code_nxt[ptr - 1'b1] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code   <= '0;
         result <= '0;
      end else begin
         code <= code_nxt;
         if (last_trial) result <= code_nxt;
      end
   end

   a_r4_half_scale_first: assert property (@(posedge clk) disable iff (rst)
      in_sample |=> (code == HALF_SCALE));

   a_r5_keep_on_one: assert property (@(posedge clk) disable iff (rst)
      (in_trial && cmp) |=> code[$past(ptr)]);

   a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
      !last_trial |=> $stable(result));

endmodule

// File: rtl/sar_diff_arms.sv
module sar_diff_arms
   import sar_diff_pkg::*;
#(
   parameter int NBITS = 10,
   parameter int SW    = 2 * NBITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold_input,
   input  logic [NBITS-1:0] code,
   output logic [SW-1:0]    sel_p,
   output logic [SW-1:0]    sel_n
);

   for (genvar i = 0; i < NBITS; i++) begin : g_cap
      arm_sel_e p_sel, n_sel;

      always_comb begin
         if (hold_input) begin
            p_sel = ARM_IN;
            n_sel = ARM_IN;
         end else if (code[i]) begin
            p_sel = ARM_VP;
            n_sel = ARM_VN;
         end else begin
            p_sel = ARM_VN;
            n_sel = ARM_VP;
         end
      end

      assign sel_p[2*i +: 2] = p_sel;
      assign sel_n[2*i +: 2] = n_sel;

      a_r8_no_code3: assert property (@(posedge clk) disable iff (rst)
         (sel_p[2*i +: 2] != 2'b11) && (sel_n[2*i +: 2] != 2'b11));

      a_r7_pair_opposed: assert property (@(posedge clk) disable iff (rst)
         (sel_p[2*i +: 2] != 2'b00) |-> (sel_n[2*i +: 2] == ~sel_p[2*i +: 2]));
   end

endmodule

// File: rtl/sar_diff_ctrl.sv
module sar_diff_ctrl #(
   parameter int NBITS = 10,
   parameter int PW    = $clog2(NBITS),
   parameter int SW    = 2 * NBITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             cmp,
   output logic [SW-1:0]    sel_p,
   output logic [SW-1:0]    sel_n,
   output logic [NBITS-1:0] result,
   output logic             done
);

   if (NBITS < 2) begin : g_bad_width
      $error("sar_diff_ctrl: NBITS must be at least 2");
   end
   if (SW != 2 * NBITS) begin : g_bad_sw
      $error("sar_diff_ctrl: SW must equal 2*NBITS");
   end
   if ((1 << PW) < NBITS) begin : g_bad_pw
      $error("sar_diff_ctrl: PW too narrow for NBITS");
   end

   logic             in_sample;
   logic             in_trial;
   logic             last_trial;
   logic [PW-1:0]    ptr;
   logic [NBITS-1:0] code;

   sar_diff_seq #(.NBITS(NBITS), .PW(PW)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .in_sample  (in_sample),
      .in_trial   (in_trial),
      .ptr        (ptr),
      .last_trial (last_trial),
      .done       (done)
   );

   sar_diff_code #(.NBITS(NBITS), .PW(PW)) u_code (
      .clk        (clk),
      .rst        (rst),
      .in_sample  (in_sample),
      .in_trial   (in_trial),
      .last_trial (last_trial),
      .ptr        (ptr),
      .cmp        (cmp),
      .code       (code),
      .result     (result)
   );

   sar_diff_arms #(.NBITS(NBITS), .SW(SW)) u_arms (
      .clk        (clk),
      .rst        (rst),
      .hold_input (!in_trial),
      .code       (code),
      .sel_p      (sel_p),
      .sel_n      (sel_n)
   );

   a_r2_input_outside_trials: assert property (@(posedge clk) disable iff (rst)
      !in_trial |-> (sel_p == '0 && sel_n == '0));

endmodule

// File: tb/sar_diff_ctrl_test.sv
module sar_diff_ctrl_test;

   localparam int N  = 10;
   localparam int SW = 2 * N;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          cmp = 1'b0;
   logic [SW-1:0] sel_p;
   logic [SW-1:0] sel_n;
   logic [N-1:0]  result;
   logic          done;

   int nvec = 0;
   int nerr = 0;

   always #2.5 clk = ~clk;

   sar_diff_ctrl #(.NBITS(N)) uut (
      .clk(clk), .rst(rst), .start(start), .cmp(cmp),
      .sel_p(sel_p), .sel_n(sel_n), .result(result), .done(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected select vectors for a given trial code (R6, R7)
   function automatic logic [SW-1:0] exp_p(input logic [N-1:0] c);
      logic [SW-1:0] v;
      for (int i = 0; i < N; i++) v[2*i +: 2] = c[i] ? 2'b01 : 2'b10;
      return v;
   endfunction

   function automatic logic [SW-1:0] exp_n(input logic [N-1:0] c);
      logic [SW-1:0] v;
      for (int i = 0; i < N; i++) v[2*i +: 2] = c[i] ? 2'b10 : 2'b01;
      return v;
   endfunction

   task automatic tick;
      @(negedge clk);
   endtask

   // One conversion of modelled input vin; called at a negedge while idle.
   // inject_at >= 0 pulses start during that trial index (R10).
   // Returns at the negedge where done is expected high.
   task automatic run_conv(input int vin, input int inject_at, input string tag);
      logic [N-1:0] decided = '0;
      logic [N-1:0] trial;
      logic [N-1:0] held = result;
      start = 1'b1;
      tick();
      start = 1'b0;
      // sample cycle (R3)
      chk(sel_p == '0 && sel_n == '0, {"R3 sample selects ", tag}, sel_p, 0);
      chk(done == 1'b0, {"R9 done low in sample ", tag}, done, 0);
      tick();
      for (int k = N - 1; k >= 0; k--) begin
         trial = decided | (N'(1) << k);
         if (k == N - 1)
            chk(trial == (N'(1) << (N - 1)) && sel_p == exp_p(trial), {"R4 first trial ", tag}, sel_p, exp_p(trial));
         chk(sel_p == exp_p(trial), {"R6 P-arm trial code ", tag}, sel_p, exp_p(trial));
         chk(sel_n == exp_n(trial), {"R7 N-arm trial code ", tag}, sel_n, exp_n(trial));
         chk(result == held, {"R9 result held ", tag}, result, held);
         cmp   = (vin >= int'(trial));
         start = (k == inject_at);
         if (cmp) decided = trial;
         tick();
         start = 1'b0;
      end
      cmp = 1'b0;
      chk(done == 1'b1, {"R9 done pulse ", tag}, done, 1);
      chk(result == N'(vin), {"R5 result code ", tag}, result, vin);
      chk(sel_p == '0 && sel_n == '0, {"R2 back to input ", tag}, sel_p, 0);
   endtask

   task automatic t_reset;
      tick(); tick();
      chk(result == '0, "R1 result cleared", result, 0);
      chk(done == 1'b0, "R1 done low", done, 0);
      chk(sel_p == '0 && sel_n == '0, "R1 selects input", {sel_p, sel_n}, 0);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk(sel_p == '0 && sel_n == '0 && !done, "R2 idle selects", sel_p, 0);
      end
   endtask

   task automatic t_codes;
      int vals[6] = '{0, 1023, 512, 511, 341, 682};
      foreach (vals[i]) begin
         run_conv(vals[i], -1, "codes");
         tick();
         chk(done == 1'b0, "R9 done one cycle", done, 0);
      end
   endtask

   task automatic t_ignore_start;
      run_conv(100, 5, "ignore");
      for (int i = 0; i < 14; i++) begin
         tick();
         chk(!done && sel_p == '0 && sel_n == '0, "R10 no second conversion", sel_p, 0);
      end
      chk(result == N'(100), "R10 result unchanged", result, 100);
   endtask

   task automatic t_back_to_back;
      run_conv(777, -1, "b2b first");
      run_conv(42, -1, "R11 b2b second");
      tick();
   endtask

   task automatic t_mid_reset;
      start = 1'b1; tick(); start = 1'b0;
      tick(); tick(); tick();
      rst = 1'b1; tick();
      rst = 1'b0;
      chk(result == '0, "R1 reset clears result", result, 0);
      chk(!done && sel_p == '0 && sel_n == '0, "R1 reset to idle", sel_p, 0);
      tick();
      chk(sel_p == '0 && !done, "R1 stays idle", sel_p, 0);
   endtask

   initial begin
      #(200000 * 5);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      t_reset();
      t_codes();
      t_ignore_start();
      t_back_to_back();
      t_mid_reset();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule